// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block collects interrupt requests for a small CPU and presents one winner at a time. There is one non-maskable request input that is edge detected, a group of external request lines and a group of on-chip peripheral request lines. Each maskable source has its own enable bit and a one-bit priority level. The CPU supplies two mask bits (`mask_i` and `mask_ui`). A system-level mode bit (`mask_mode`) picks the masking scheme. With `mask_mode = 1`, only `mask_i` gates the maskable sources. With `mask_mode = 0`, the two bits together form a two-level mask: with `mask_i` set, a cleared `mask_ui` still lets priority-1 sources through.

Accepted requests are latched into a pending register. A pending request stays there while it is masked, and it is presented again once the mask allows it. The CPU sees a registered request flag `cpu_req` and a registered source index `cpu_idx`. These form a valid/ready pair with `cpu_ack`. A request is accepted in a cycle where both `cpu_req` and `cpu_ack` are high. That acceptance clears only the pending bit named by `cpu_idx`. There is no back-pressure on the request inputs. While `cpu_ack` stays low, the index may change, because a higher-priority source that arrives takes over the output. The output reflects an acceptance one clock later, so the CPU should leave `cpu_ack` low in the cycle that follows an acceptance.

Index encoding: value 0 is the non-maskable request. Value s+1 is maskable source s. External line k is source k. Peripheral line k is source `N_EXT`+k.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_req` is 0 and `cpu_idx` is 0, and every pending flag is cleared.
- R2: While `standby` is high, the outputs are driven inactive from the next clock and all pending flags are cleared. A rising edge on `nmi_in` during standby is discarded.
- R3: With `mask_mode = 1`, `mask_i = 1` blocks every maskable source, whatever its level. `mask_i = 0` lets every enabled maskable source through.
- R4: With `mask_mode = 0` and `mask_i = 0`, every enabled maskable source is accepted, whatever the value of `mask_ui`.
- R5: With `mask_mode = 0`, `mask_i = 1` and `mask_ui = 0`, only maskable sources whose `src_lvl` bit is 1 are accepted.
- R6: With `mask_mode = 0`, `mask_i = 1` and `mask_ui = 1`, no maskable source is accepted.
- R7: A request on a source whose `src_en` bit is 0 is not latched. A pending source whose enable is later cleared is not presented until its enable is set again.
- R8: The non-maskable request wins over all maskable ones. Level-1 sources win over level-0 sources. Within one level, the lowest source number wins.
- R9: A rising edge on `nmi_in` sets a pending flag that is presented as index 0 under every mask setting. The flag is cleared by acknowledge, and a level held high does not set it again.
- R10: An acknowledge clears only the pending bit named by `cpu_idx`. The next-highest pending source is then presented.
- R11: `cpu_req` and `cpu_idx` are registered. They follow a pending or mask change one clock later. `cpu_idx` is 0 whenever `cpu_req` is 0.
- R12: A request latched while masked stays pending. It is presented one clock after the mask is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Hardware standby; clears state and silences outputs |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| ext_req | input | N_EXT | External request lines (sources 0..N_EXT-1) |
| per_req | input | N_PER | Peripheral request lines (sources N_EXT..N_SRC-1) |
| src_en | input | N_SRC | Per-source enable |
| src_lvl | input | N_SRC | Per-source priority level (1 = high) |
| mask_mode | input | 1 | 1: single-bit masking, 0: two-level masking |
| mask_i | input | 1 | CPU mask bit I |
| mask_ui | input | 1 | CPU mask bit UI |
| cpu_ack | input | 1 | CPU accepts the presented request |
| cpu_req | output | 1 | A request is presented |
| cpu_idx | output | $clog2(N_SRC+1) | Index of the presented request |

## Verification
The bench walks every combination of the mode bit and the two mask bits against mixed-level request sets. A design that swapped the roles of `mask_i` and `mask_ui`, or that let level-1 sources through in single-bit mode, would present a source where none is expected. Priority checks mix levels against source numbers. An arbiter that scanned from the wrong end, or that ignored levels, would report the wrong index. Acknowledge is tested with two pending sources: clearing every pending bit would drop the second one, and clearing none would repeat the first. Standby, enable removal and mask release are also tested: dropping a masked request instead of holding it, or letting an edge seen during standby survive, both show up as a missing or extra request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic mode;  // 1: single-bit masking
    logic i;
    logic ui;
  } mask_cfg_t;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend
);
  for (genvar s = 0; s < W; s++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend[s] <= 1'b0;
      else if (clr_all)      pend[s] <= 1'b0;
      else if (set_vec[s])   pend[s] <= 1'b1;
      else if (clr_vec[s])   pend[s] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
  import irqc_pkg::*;
#(
  parameter int W = 8
) (
  input  mask_cfg_t    cfg,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] elig_hi,
  output logic [W-1:0] elig_lo
);
  logic pass_hi, pass_lo;

  // level-1 passes unless both mask bits are set (two-level mode)
  assign pass_hi = cfg.mode ? ~cfg.i : ~(cfg.i & cfg.ui);
  assign pass_lo = ~cfg.i;

  assign elig_hi = pend & en &  lvl & {W{pass_hi}};
  assign elig_lo = pend & en & ~lvl & {W{pass_lo}};
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic          nmi_pend,
  input  logic [W-1:0]  elig_hi,
  input  logic [W-1:0]  elig_lo,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic          hi_hit, lo_hit;
  logic [IW-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    // scan downward so the lowest number is assigned last
    for (int s = W - 1; s >= 0; s--) begin
      if (elig_hi[s]) begin
        hi_hit = 1'b1;
        hi_idx = IW'(s + 1);
      end
      if (elig_lo[s]) begin
        lo_hit = 1'b1;
        lo_idx = IW'(s + 1);
      end
    end
  end

  always_comb begin
    found = nmi_pend | hi_hit | lo_hit;
    if (nmi_pend)    idx = '0;
    else if (hi_hit) idx = hi_idx;
    else if (lo_hit) idx = lo_idx;
    else             idx = '0;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int N_EXT = 4,
  parameter int N_PER = 4,
  localparam int N_SRC = N_EXT + N_PER,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             nmi_in,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_PER-1:0] per_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             mask_mode,
  input  logic             mask_i,
  input  logic             mask_ui,
  input  logic             cpu_ack,
  output logic             cpu_req,
  output logic [IDX_W-1:0] cpu_idx
);
  mask_cfg_t        cfg;
  logic             nmi_q, nmi_rise, nmi_pend, take;
  logic [N_SRC-1:0] set_vec, clr_vec, pend, elig_hi, elig_lo;
  logic             found;
  logic [IDX_W-1:0] pick_idx;

  assign cfg      = '{mode: mask_mode, i: mask_i, ui: mask_ui};
  assign take     = cpu_ack & cpu_req;
  assign nmi_rise = nmi_in & ~nmi_q;
  assign set_vec  = {per_req, ext_req} & src_en;

  for (genvar s = 0; s < N_SRC; s++) begin : g_clr
    assign clr_vec[s] = take && (cpu_idx == IDX_W'(s + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      if (standby)                        nmi_pend <= 1'b0;
      else if (nmi_rise)                  nmi_pend <= 1'b1;
      else if (take && cpu_idx == '0)     nmi_pend <= 1'b0;
    end
  end

  irqc_pending #(.W(N_SRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (standby),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend    (pend)
  );

  irqc_gate #(.W(N_SRC)) u_gate (
    .cfg     (cfg),
    .pend    (pend),
    .en      (src_en),
    .lvl     (src_lvl),
    .elig_hi (elig_hi),
    .elig_lo (elig_lo)
  );

  irqc_pick #(.W(N_SRC), .IW(IDX_W)) u_pick (
    .nmi_pend (nmi_pend),
    .elig_hi  (elig_hi),
    .elig_lo  (elig_lo),
    .found    (found),
    .idx      (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_req <= 1'b0;
      cpu_idx <= '0;
    end else if (standby) begin
      cpu_req <= 1'b0;
      cpu_idx <= '0;
    end else begin
      cpu_req <= found;
      cpu_idx <= pick_idx;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic             mask_mode,
  input logic             mask_i,
  input logic             mask_ui,
  input logic [N_SRC-1:0] src_en,
  input logic [N_SRC-1:0] src_lvl,
  input logic             cpu_req,
  input logic [IDX_W-1:0] cpu_idx
);
  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !cpu_req);

  a_r11_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> cpu_idx == '0);

  a_r11_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> cpu_idx <= IDX_W'(N_SRC));

  a_r3_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && $past(mask_mode && mask_i)) |-> cpu_idx == '0);

  a_r6_both_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && $past(!mask_mode && mask_i && mask_ui)) |-> cpu_idx == '0);

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    a_r7_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_idx == IDX_W'(s + 1)) |-> $past(src_en[s]));

    a_r5_level_one_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_idx == IDX_W'(s + 1) && $past(!mask_mode && mask_i))
        |-> $past(src_lvl[s]));
  end
endmodule

bind irq_mask_ctrl irqc_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby   (standby),
  .mask_mode (mask_mode),
  .mask_i    (mask_i),
  .mask_ui   (mask_ui),
  .src_en    (src_en),
  .src_lvl   (src_lvl),
  .cpu_req   (cpu_req),
  .cpu_idx   (cpu_idx)
);

// File: tb/test_irq_mask_ctrl.sv
`timescale 1ns/1ps
module test_irq_mask_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       nmi_in = 1'b0;
  logic [3:0] ext_req = '0;
  logic [3:0] per_req = '0;
  logic [7:0] src_en = '0;
  logic [7:0] src_lvl = '0;
  logic       mask_mode = 1'b1;
  logic       mask_i = 1'b0;
  logic       mask_ui = 1'b0;
  logic       cpu_ack = 1'b0;
  logic       cpu_req;
  logic [3:0] cpu_idx;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  irq_mask_ctrl #(.N_EXT(4), .N_PER(4)) i_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby), .nmi_in(nmi_in),
    .ext_req(ext_req), .per_req(per_req), .src_en(src_en), .src_lvl(src_lvl),
    .mask_mode(mask_mode), .mask_i(mask_i), .mask_ui(mask_ui),
    .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_idx(cpu_idx)
  );

  // {mode, i, ui, nmi, en[8], lvl[8], req[8], exp_req, exp_idx[4]}
  localparam logic [32:0] VEC [12] = '{
    {1'b1,1'b0,1'b0,1'b0, 8'hFF, 8'h00, 8'h10, 1'b1, 4'd5},  // R3 open
    {1'b1,1'b1,1'b0,1'b0, 8'hFF, 8'hFF, 8'h01, 1'b0, 4'd0},  // R3 masked, level ignored
    {1'b0,1'b0,1'b1,1'b0, 8'hFF, 8'h00, 8'h04, 1'b1, 4'd3},  // R4 UI ignored
    {1'b0,1'b1,1'b0,1'b0, 8'hFF, 8'h02, 8'h03, 1'b1, 4'd2},  // R5 level-1 passes
    {1'b0,1'b1,1'b0,1'b0, 8'hFF, 8'h00, 8'h08, 1'b0, 4'd0},  // R5 level-0 held
    {1'b0,1'b1,1'b1,1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 4'd0},  // R6 all masked
    {1'b0,1'b1,1'b1,1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 4'd0},  // R9 NMI through R6 mask
    {1'b1,1'b0,1'b0,1'b0, 8'hFE, 8'h00, 8'h01, 1'b0, 4'd0},  // R7 disabled source
    {1'b1,1'b0,1'b0,1'b0, 8'hFF, 8'h80, 8'h81, 1'b1, 4'd8},  // R8 level beats number
    {1'b1,1'b0,1'b0,1'b0, 8'hFF, 8'h00, 8'h0C, 1'b1, 4'd3},  // R8 lowest number
    {1'b1,1'b0,1'b0,1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 4'd0},  // R8 NMI first
    {1'b1,1'b1,1'b0,1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 4'd0}   // R9 NMI through R3 mask
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic xr, input logic [3:0] xi);
    n_chk++;
    if (cpu_req !== xr || cpu_idx !== xi) begin
      n_bad++;
      $display("FAIL %s: req/idx = %0b/%0d, expected %0b/%0d", tag, cpu_req, cpu_idx, xr, xi);
    end
  endtask

  task automatic reset_pulse();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic [7:0] r);
    {per_req, ext_req} = r;
    step();
    {per_req, ext_req} = '0;
    step();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2;
    check("R1 outputs idle in reset", 1'b0, 4'd0);
    step();
    rst_n = 1'b1;

    for (int v = 0; v < 12; v++) begin
      nmi_in = 1'b0;
      reset_pulse();
      {mask_mode, mask_i, mask_ui} = VEC[v][32:30];
      src_en  = VEC[v][28:21];
      src_lvl = VEC[v][20:13];
      step();
      nmi_in = VEC[v][29];
      pulse(VEC[v][12:5]);
      check($sformatf("table row %0d", v), VEC[v][4], VEC[v][3:0]);
    end
    nmi_in = 1'b0;

    // R12 / R11: held while masked, shown one clock after release
    reset_pulse();
    {mask_mode, mask_i, mask_ui} = 3'b011;
    src_en = 8'hFF; src_lvl = 8'h00;
    pulse(8'h04);
    check("R12 masked request hidden", 1'b0, 4'd0);
    mask_i = 1'b0;
    step();
    check("R11 one clock after mask release", 1'b1, 4'd3);

    // R10: acknowledge clears only the named bit
    reset_pulse();
    {mask_mode, mask_i, mask_ui} = 3'b100;
    pulse(8'h12);
    check("R10 first winner", 1'b1, 4'd2);
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step();
    check("R10 second source remains", 1'b1, 4'd5);
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step();
    check("R10 all acknowledged", 1'b0, 4'd0);

    // R9: NMI cleared by ack, held level does not re-arm
    nmi_in = 1'b1; step(); step();
    check("R9 NMI presented", 1'b1, 4'd0);
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step(); step();
    check("R9 held NMI level no re-arm", 1'b0, 4'd0);
    nmi_in = 1'b0;

    // R7: enable removed while pending
    pulse(8'h04);
    src_en = 8'hFB; step();
    check("R7 disabled pending hidden", 1'b0, 4'd0);
    src_en = 8'hFF; step();
    check("R7 re-enabled pending shown", 1'b1, 4'd3);

    // R1: reset mid-operation
    rst_n = 1'b0; #1;
    check("R1 async reset clears outputs", 1'b0, 4'd0);
    step(); rst_n = 1'b1; step(); step();
    check("R1 pending cleared by reset", 1'b0, 4'd0);

    // R2: standby clears and drops NMI edges
    pulse(8'h01);
    check("R2 setup pending", 1'b1, 4'd1);
    standby = 1'b1; step();
    check("R2 standby silences outputs", 1'b0, 4'd0);
    nmi_in = 1'b1; step();
    standby = 1'b0; step(); step();
    check("R2 pending and NMI edge dropped", 1'b0, 4'd0);
    nmi_in = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule